// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Timing Generator

This block produces the switching period and the gate-drive pulse of a current-mode power converter controller. A counter running on the system clock defines each switching period. The period length is not constant. It walks up and down in a linear triangle between a short and a long limit around the nominal length, which spreads the switching frequency over a band of about plus and minus 7.5 percent. The supervisor selects one of two nominal frequencies with a single pin. That choice is taken up at a period boundary.

At the first clock of every period the drive output goes high. It stays high until the earliest of three events:
- the current-sense comparator reports a trip, after a two-flop synchronizer and outside the leading-edge blanking window;
- the period reaches its maximum-duty limit, 80 percent of the length of that same period;
- the supervisor removes the drive enable.

A ramp-phase output marks the part of each period in which the slope-compensation ramp should rise. The analog comparator, the ramp source and the gate driver sit outside the block. The block sees them only as digital flags.

Top module: `pwm_jitter_timer`

## Requirements
- R1: While reset is held, drive_out, ramp_active and period_start are 0. The first period starts on the first clock edge after reset is released, with the shortest length of frequency A.
- R2: For each frequency, the nominal length is P = CLK_HZ / F clocks and the deviation is D = P * 75 / 1000 clocks (both truncated). Period lengths reach exactly P - D and P + D, and never go outside that range.
- R3: Period lengths follow a triangle with step S = max(1, 2D / H), where H = JIT_SWEEP_US * (F/1000) / 2000 is the number of periods in half a sweep. Rising: when length + S is at least P + D, the next length is P + D and the direction turns to falling; otherwise the next length is length + S. Falling: when length is at most P - D + S, the next length is P - D and the direction turns to rising; otherwise the next length is length - S.
- R4: freq_sel (0 = frequency A, 1 = frequency B) is sampled at each period boundary. When it differs from the frequency in use, the period after the next one has the shortest length of the new frequency and the sweep rises from there. The period in between keeps the length already scheduled.
- R5: period_start is high for exactly the first clock of every period. With drive_en high, drive_out is high in that clock.
- R6: With no comparator trip and drive_en high, drive_out is high for exactly floor(len * 80 / 100) clocks from the period start, where len is that period's length.
- R7: When cs_trip rises during clock j of a period (clock 0 = period start), drive_out is high for min(cap, max(j + 3, B + 1)) clocks, where cap is the limit from R6. The extra clocks are two synchronizer stages and one registered decision.
- R8: The comparator is ignored while the period counter is below the blanking count B = ceil(BLANK_NS * CLK_HZ / 1e9). With cs_trip held high from before the period start, drive_out is high for exactly B + 1 clocks.
- R9: ramp_active is high for the first floor(len * 80 / 100) clocks of each period and low for the rest. It does not depend on cs_trip or drive_en.
- R10: drive_en low forces drive_out low in the same clock. The pulse then stays off for the rest of that period, even if drive_en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 1 | Nominal frequency choice: 0 = A, 1 = B |
| drive_en | input | 1 | Supervisor enable for the gate pulse |
| cs_trip | input | 1 | Asynchronous current-sense comparator flag, high = sense level reached |
| drive_out | output | 1 | Gate-drive pulse request |
| ramp_active | output | 1 | High while the compensation ramp should rise |
| period_start | output | 1 | One-clock marker at the start of each period |

## Verification
The sweep is traced period by period through complete triangles for both frequencies. These runs use a step larger than one, so the clamping and turn-around at each end can be told apart from plain stepping. The comparator is raised at every notable offset:
- inside the blanking window;
- at its edge;
- early and mid-period;
- just before, at and after the duty limit.

These offsets separate the blanking, synchronizer latency and cap paths. The comparator is also held across a boundary. The enable is dropped and restored inside a period, which shows whether a pulse can restart. A frequency change in mid-sweep shows the one-period handover and the restart at the new minimum.

// File: rtl/pwm_jit_pkg.sv
package pwm_jit_pkg;

  typedef enum logic {
    FSEL_A = 1'b0,
    FSEL_B = 1'b1
  } fsel_e;

  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // per-period length change so that one half sweep covers the full span
  function automatic int sweep_step(input int dev, input int half_periods);
    int s;
    if (half_periods <= 0) return 1;
    s = (2 * dev) / half_periods;
    return (s < 1) ? 1 : s;
  endfunction

endpackage

// File: rtl/pwm_sense_sync.sv
module pwm_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stg_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= 1'b0;
        else        stg_q <= async_in;
      end
      assign sync_out = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], async_in};
      end
      assign sync_out = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pwm_period_sweep.sv
module pwm_period_sweep
  import pwm_jit_pkg::*;
#(
  parameter int CW     = 11,
  parameter int MIN_A  = 1423,
  parameter int MAX_A  = 1653,
  parameter int STEP_A = 1,
  parameter int MIN_B  = 925,
  parameter int MAX_B  = 1075,
  parameter int STEP_B = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          sel,
  output logic [CW-1:0] next_len
);

  localparam logic [CW-1:0] LO_A = CW'(MIN_A);
  localparam logic [CW-1:0] HI_A = CW'(MAX_A);
  localparam logic [CW-1:0] ST_A = CW'(STEP_A);
  localparam logic [CW-1:0] LO_B = CW'(MIN_B);
  localparam logic [CW-1:0] HI_B = CW'(MAX_B);
  localparam logic [CW-1:0] ST_B = CW'(STEP_B);

  logic [CW-1:0] nxt_q;
  sweep_e        dir_q;
  fsel_e         mode_q;
  fsel_e         sel_e;

  logic [CW-1:0] lo_cur, hi_cur, st_cur, lo_new;
  logic [CW:0]   up_sum, dn_lim;

  assign sel_e = fsel_e'(sel);

  always_comb begin
    lo_cur = (mode_q == FSEL_B) ? LO_B : LO_A;
    hi_cur = (mode_q == FSEL_B) ? HI_B : HI_A;
    st_cur = (mode_q == FSEL_B) ? ST_B : ST_A;
    lo_new = (sel_e == FSEL_B) ? LO_B : LO_A;
    up_sum = {1'b0, nxt_q} + {1'b0, st_cur};
    dn_lim = {1'b0, lo_cur} + {1'b0, st_cur};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_q  <= LO_A;
      dir_q  <= SWEEP_UP;
      mode_q <= FSEL_A;
    end else if (advance) begin
      if (sel_e != mode_q) begin
        nxt_q  <= lo_new;
        dir_q  <= SWEEP_UP;
        mode_q <= sel_e;
      end else if (dir_q == SWEEP_UP) begin
        if (up_sum >= {1'b0, hi_cur}) begin
          nxt_q <= hi_cur;
          dir_q <= SWEEP_DOWN;
        end else begin
          nxt_q <= up_sum[CW-1:0];
        end
      end else begin
        if ({1'b0, nxt_q} <= dn_lim) begin
          nxt_q <= lo_cur;
          dir_q <= SWEEP_UP;
        end else begin
          nxt_q <= nxt_q - st_cur;
        end
      end
    end
  end

  assign next_len = nxt_q;

endmodule

// File: rtl/pwm_pulse_core.sv
module pwm_pulse_core #(
  parameter int CW        = 11,
  parameter int DUTY_PCT  = 80,
  parameter int BLANK_CYC = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] next_len,
  input  logic          cs_hit,
  input  logic          drive_en,
  output logic          wrap,
  output logic          drive_out,
  output logic          ramp_active,
  output logic          period_start
);

  localparam int            PW      = CW + 7;
  localparam logic [CW-1:0] BLANK_W = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, len_q, cap_q, cap_d;
  logic [PW-1:0] prod;
  logic          stop_q, start_q;
  logic          in_cap, past_blank, kill;

  // duty limit follows the length that is about to be loaded
  assign prod  = PW'(next_len) * PW'(DUTY_PCT);
  assign cap_d = CW'(prod / PW'(100));

  assign wrap       = (cnt_q == (len_q - CW'(1)));
  assign in_cap     = (cnt_q < cap_q);
  assign past_blank = (cnt_q >= BLANK_W);
  assign kill       = !drive_en || (cs_hit && past_blank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= CW'(1);
      cap_q   <= '0;
      stop_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= wrap;
      if (wrap) begin
        cnt_q  <= '0;
        len_q  <= next_len;
        cap_q  <= cap_d;
        stop_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        if (kill) stop_q <= 1'b1;
      end
    end
  end

  assign drive_out    = drive_en && !stop_q && in_cap;
  assign ramp_active  = in_cap;
  assign period_start = start_q;

endmodule

// File: rtl/pwm_jitter_timer.sv
module pwm_jitter_timer
  import pwm_jit_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int FREQ_A_HZ    = 65_000,
  parameter int FREQ_B_HZ    = 100_000,
  parameter int JIT_PERMILLE = 75,
  parameter int JIT_SWEEP_US = 6000,
  parameter int DUTY_PCT     = 80,
  parameter int BLANK_NS     = 180,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_sel,
  input  logic drive_en,
  input  logic cs_trip,
  output logic drive_out,
  output logic ramp_active,
  output logic period_start
);

  localparam int NOM_A  = CLK_HZ / FREQ_A_HZ;
  localparam int DEV_A  = NOM_A * JIT_PERMILLE / 1000;
  localparam int MIN_A  = NOM_A - DEV_A;
  localparam int MAX_A  = NOM_A + DEV_A;
  localparam int HALF_A = JIT_SWEEP_US * (FREQ_A_HZ / 1000) / 2000;
  localparam int STEP_A = sweep_step(DEV_A, HALF_A);

  localparam int NOM_B  = CLK_HZ / FREQ_B_HZ;
  localparam int DEV_B  = NOM_B * JIT_PERMILLE / 1000;
  localparam int MIN_B  = NOM_B - DEV_B;
  localparam int MAX_B  = NOM_B + DEV_B;
  localparam int HALF_B = JIT_SWEEP_US * (FREQ_B_HZ / 1000) / 2000;
  localparam int STEP_B = sweep_step(DEV_B, HALF_B);

  localparam int CW        = $clog2(imax(MAX_A, MAX_B) + 1);
  localparam int BLANK_RAW = ((CLK_HZ / 1000) * BLANK_NS + 999_999) / 1_000_000;
  localparam int BLANK_CYC = (BLANK_RAW < 1) ? 1 : BLANK_RAW;

  logic          cs_hit;
  logic          wrap;
  logic [CW-1:0] next_len;

  pwm_sense_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cs_trip),
    .sync_out (cs_hit)
  );

  pwm_period_sweep #(
    .CW     (CW),
    .MIN_A  (MIN_A),
    .MAX_A  (MAX_A),
    .STEP_A (STEP_A),
    .MIN_B  (MIN_B),
    .MAX_B  (MAX_B),
    .STEP_B (STEP_B)
  ) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (wrap),
    .sel      (freq_sel),
    .next_len (next_len)
  );

  pwm_pulse_core #(
    .CW        (CW),
    .DUTY_PCT  (DUTY_PCT),
    .BLANK_CYC (BLANK_CYC)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .next_len     (next_len),
    .cs_hit       (cs_hit),
    .drive_en     (drive_en),
    .wrap         (wrap),
    .drive_out    (drive_out),
    .ramp_active  (ramp_active),
    .period_start (period_start)
  );

endmodule

// File: rtl/pwm_jitter_timer_chk.sv
module pwm_jitter_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_en,
  input logic drive_out,
  input logic ramp_active,
  input logic period_start
);

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R6
  drive_in_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_out |-> ramp_active);

  // R8
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && drive_en) |=> (drive_out || !drive_en));

  // R9
  ramp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_active) |-> period_start);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_out) |-> period_start);

  // R10
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> !drive_out);

endmodule

bind pwm_jitter_timer pwm_jitter_timer_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .drive_en     (drive_en),
  .drive_out    (drive_out),
  .ramp_active  (ramp_active),
  .period_start (period_start)
);

// File: tb/test_pwm_jitter_timer.sv
module test_pwm_jitter_timer;

  localparam int CLK_HZ   = 10_000_000;
  localparam int FA       = 65_000;
  localparam int FB       = 100_000;
  localparam int PERMIL   = 75;
  localparam int SWEEP_US = 100;
  localparam int DUTY     = 80;
  localparam int BL_NS    = 180;

  localparam int NOM_A  = CLK_HZ / FA;
  localparam int DEV_A  = NOM_A * PERMIL / 1000;
  localparam int MIN_A  = NOM_A - DEV_A;
  localparam int MAX_A  = NOM_A + DEV_A;
  localparam int HALF_A = SWEEP_US * FA / 2_000_000;
  localparam int NOM_B  = CLK_HZ / FB;
  localparam int DEV_B  = NOM_B * PERMIL / 1000;
  localparam int MIN_B  = NOM_B - DEV_B;
  localparam int MAX_B  = NOM_B + DEV_B;
  localparam int HALF_B = SWEEP_US * FB / 2_000_000;
  localparam int BLANK  = ((CLK_HZ / 1000) * BL_NS + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n, drive_en, cs_trip, freq_sel;
  logic drive_out, ramp_active, period_start;

  int n_vec, n_bad;
  int m_cur, m_nxt;
  bit m_up, m_mode;
  bit cs_held_prev;
  bit done;
  int obs_min, obs_max;

  always #5 clk = ~clk;

  pwm_jitter_timer #(
    .CLK_HZ       (CLK_HZ),
    .FREQ_A_HZ    (FA),
    .FREQ_B_HZ    (FB),
    .JIT_PERMILLE (PERMIL),
    .JIT_SWEEP_US (SWEEP_US),
    .DUTY_PCT     (DUTY),
    .BLANK_NS     (BL_NS),
    .SYNC_STAGES  (2)
  ) i_pwm_jitter_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_sel     (freq_sel),
    .drive_en     (drive_en),
    .cs_trip      (cs_trip),
    .drive_out    (drive_out),
    .ramp_active  (ramp_active),
    .period_start (period_start)
  );

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int step_of(input bit sel);
    int dev, half;
    dev  = sel ? DEV_B : DEV_A;
    half = sel ? HALF_B : HALF_A;
    if (half <= 0) return 1;
    return imax(1, (2 * dev) / half);
  endfunction

  // R3 / R4 sequence model, applied at each period boundary
  function automatic void model_advance(input bit sel);
    int lo, hi, s;
    if (sel != m_mode) begin
      m_mode = sel;
      m_up   = 1'b1;
      m_nxt  = sel ? MIN_B : MIN_A;
    end else begin
      lo = m_mode ? MIN_B : MIN_A;
      hi = m_mode ? MAX_B : MAX_A;
      s  = step_of(m_mode);
      if (m_up) begin
        if (m_nxt + s >= hi) begin m_nxt = hi; m_up = 1'b0; end
        else m_nxt = m_nxt + s;
      end else begin
        if (m_nxt <= lo + s) begin m_nxt = lo; m_up = 1'b1; end
        else m_nxt = m_nxt - s;
      end
    end
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Runs one period from the negedge of its clock 0; ends at the next period's clock 0.
  task automatic run_period(input int cs_at, input bit cs_keep, input int en_off_at,
                            input int en_on_at, input int sel_at, input bit sel_val,
                            input string dtag, input string ptag);
    int p, cap, on;
    int d_err, r_err, s_err, d_cnt;
    p   = m_cur;
    cap = p * DUTY / 100;
    on  = cap;
    d_err = 0; r_err = 0; s_err = 0; d_cnt = 0;
    if (cs_held_prev)  on = imin(on, BLANK + 1);
    else if (cs_at >= 0) on = imin(on, imax(cs_at + 3, BLANK + 1));
    if (en_off_at >= 0) on = imin(on, en_off_at);
    for (int j = 0; j < p; j++) begin
      if (j == cs_at) cs_trip = 1'b1;
      if (j == p - 3 && !cs_keep) cs_trip = 1'b0;
      if (j == en_off_at) drive_en = 1'b0;
      if (j == en_on_at) drive_en = 1'b1;
      if (j == sel_at) freq_sel = sel_val;
      #1;
      if (drive_out !== (j < on)) d_err++;
      if (drive_out === 1'b1) d_cnt++;
      if (ramp_active !== (j < cap)) r_err++;
      if (period_start !== (j == 0)) s_err++;
      @(negedge clk);
    end
    check(ptag, "period length in clocks (-1 = start marker misplaced)", (s_err == 0) ? p : -1, p);
    check(dtag, "drive-high clocks (-1 = wrong placement)", (d_err == 0) ? d_cnt : -1, on);
    check("R9", "ramp-phase mismatched clocks", r_err, 0);
    if (s_err == 0) begin
      obs_min = imin(obs_min, p);
      obs_max = imax(obs_max, p);
    end
    cs_held_prev = cs_keep && cs_trip;
    m_cur = m_nxt;
    model_advance(freq_sel);
  endtask

  initial begin
    done = 1'b0;
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; drive_en = 1'b1; cs_trip = 1'b0; freq_sel = 1'b0;
    cs_held_prev = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "drive_out in reset", drive_out, 0);
    check("R1", "ramp_active in reset", ramp_active, 0);
    check("R1", "period_start in reset", period_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    m_mode = 1'b0; m_up = 1'b1; m_nxt = MIN_A;
    m_cur = m_nxt;
    model_advance(1'b0);
    obs_min = 1 << 30; obs_max = 0;

    // R1 first period, then the frequency-A triangle
    run_period(-1, 0, -1, -1, -1, 0, "R6", "R1");
    for (int k = 0; k < 13; k++) run_period(-1, 0, -1, -1, -1, 0, "R6", "R3");
    check("R2", "shortest period A", obs_min, MIN_A);
    check("R2", "longest period A", obs_max, MAX_A);

    // comparator placement sweep (R7, R8 blanking edge)
    run_period(0, 0, -1, -1, -1, 0, "R8", "R5");
    run_period(1, 0, -1, -1, -1, 0, "R8", "R5");
    run_period(2, 0, -1, -1, -1, 0, "R7", "R5");
    run_period(3, 0, -1, -1, -1, 0, "R7", "R3");
    run_period(9, 0, -1, -1, -1, 0, "R7", "R3");
    run_period(50, 0, -1, -1, -1, 0, "R7", "R3");
    for (int k = 2; k <= 5; k++) begin
      c = m_cur * DUTY / 100;
      run_period(c - k, 0, -1, -1, -1, 0, "R7", "R3");
    end

    // comparator held across the boundary (R8)
    run_period(40, 1, -1, -1, -1, 0, "R7", "R3");
    run_period(-1, 0, -1, -1, -1, 0, "R8", "R3");

    // enable removal and return inside a period (R10)
    run_period(-1, 0, 0, 5, -1, 0, "R10", "R5");
    run_period(-1, 0, 60, 63, -1, 0, "R10", "R3");
    run_period(30, 0, 10, 12, -1, 0, "R10", "R3");
    run_period(-1, 0, -1, -1, -1, 0, "R6", "R3");

    // switch to frequency B mid-period (R4)
    run_period(-1, 0, -1, -1, 10, 1, "R6", "R4");
    run_period(-1, 0, -1, -1, -1, 1, "R6", "R4");
    obs_min = 1 << 30; obs_max = 0;
    for (int k = 0; k < 16; k++) run_period(-1, 0, -1, -1, -1, 1, "R6", "R4");
    check("R2", "shortest period B", obs_min, MIN_B);
    check("R2", "longest period B", obs_max, MAX_B);
    run_period(20, 0, -1, -1, -1, 1, "R7", "R3");
    run_period(-1, 0, 33, 40, -1, 1, "R10", "R3");

    // back to frequency A (R4)
    run_period(-1, 0, -1, -1, 5, 0, "R6", "R4");
    run_period(-1, 0, -1, -1, -1, 0, "R6", "R4");
    run_period(-1, 0, -1, -1, -1, 0, "R6", "R4");
    check("R4", "length after return to A", m_cur == (MIN_A + step_of(0)) ? 1 : 0, 1);
    run_period(-1, 0, -1, -1, -1, 0, "R6", "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule